// File: doc/BRIEF.md
# Capture Word DMA Request Generator

The block takes packed 32-bit capture words produced in the pixel-clock domain and moves them into the bus-clock domain through a small asynchronous FIFO. On the bus side it raises a DMA request line toward a bus-side engine. The engine answers with read strobes, and each strobe takes one word off the head of the FIFO. Two granularities are offered. In single mode every buffered word earns its own request, which is served by one read. In burst mode a request waits until four words are buffered and is then served by four reads in a row.

Request generation starts by itself as soon as the capture enable is high. Clearing the enable flushes the FIFO, withdraws any pending request and clears the sticky overflow flag. A word that arrives from the pixel side while the FIFO is full is dropped, and the bus side is told through the overflow flag. The design assumes the bus clock runs at more than 2.5 times the pixel clock. The FIFO depth parameter must be at least 8 and a power of two.

The request logic is a four-state machine in the bus domain:
- `ST_IDLE`: capture is off. It moves to `ST_WAIT` once `cap_en` is high.
- `ST_WAIT`: it counts buffered words. It moves to `ST_REQ` when the level reaches the need of the current mode (1 or 4), and it latches the mode at that point.
- `ST_REQ`: `dma_req` is high and read strobes are counted. After the last required strobe it moves to `ST_GAP`.
- `ST_GAP`: one cycle with the request low, then back to `ST_WAIT`.

Every state returns to `ST_IDLE` when `cap_en` is low.

Top module: `cap_dma_requester`

## Requirements
- R1: With `burst_sel`=0 and `cap_en`=1, `dma_req` rises once at least one word is buffered, and one read strobe completes the request.
- R2: With `burst_sel`=1, `dma_req` stays low while fewer than four words are buffered. It rises once four are buffered, and four read strobes complete the request.
- R3: Once raised, `dma_req` stays high until the required number of strobes (1 or 4) has been seen. It is low in the bus cycle after the last of them.
- R4: A read strobe on a non-empty FIFO returns the oldest buffered word on `rd_data` in the same cycle, and words leave in the order they were written.
- R5: A read strobe while the FIFO is empty returns zero on `rd_data` and leaves the FIFO unchanged, so the next written word is the next word read.
- R6: A word offered on `px_valid` while the FIFO (8 entries by default) is full is dropped. `ovf_flag` then goes high and stays high while `cap_en` stays high.
- R7: Clearing `cap_en` drops `dma_req` in the next bus cycle, clears `ovf_flag` and empties the FIFO, so that after re-enabling no stale word is requested or read.
- R8: After reset, `dma_req` and `ovf_flag` are 0 and `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel-side clock |
| prst_n | input | 1 | Pixel-side active-low reset |
| px_valid | input | 1 | A packed word is offered this pixel cycle |
| px_word | input | 32 | Packed capture word |
| bclk | input | 1 | Bus-side clock |
| brst_n | input | 1 | Bus-side active-low reset |
| cap_en | input | 1 | Capture enable (bus domain); low flushes |
| burst_sel | input | 1 | 1 = four-read bursts, 0 = single reads |
| dma_req | output | 1 | DMA request toward the engine |
| rd_strobe | input | 1 | Engine reads the data register this cycle |
| rd_data | output | 32 | Word returned for the current strobe |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
Read data is combinational, so `rd_data` is checked in the same bus cycle as the strobe, one time unit after the strobe is driven at the falling edge. `dma_req` is checked low at the falling edge that follows the rising edge which took the final strobe. The same holds after `cap_en` is cleared. A written word reaches the bus side only after the two-flop pointer synchroniser and the state register, so the bench waits for the request within a bounded window and does not expect a fixed cycle. Threshold and overflow checks are made only after several bus cycles of settling.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    localparam int WORD_W      = 32;
    localparam int BURST_BEATS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2,
        ST_GAP  = 2'd3
    } req_state_t;
endpackage

// File: rtl/cdr_sync.sv
module cdr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cdr_afifo.sv
module cdr_afifo #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          w_en,
    input  logic          w_valid,
    input  logic [DW-1:0] w_data,
    output logic          w_drop_tgl,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          r_flush,
    input  logic          r_pop,
    output logic [DW-1:0] r_data,
    output logic [AW:0]   r_level
);
    localparam int DEPTH = 1 << AW;

    function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DW-1:0] mem [DEPTH];

    logic [AW:0] wbin, wgray, rgray_w;
    logic [AW:0] rbin, rgray, wgray_r, wbin_r, rbin_nx;
    logic        full, empty, push;

    // ---------------- write side ----------------
    cdr_sync #(.W(AW+1)) u_rsync (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
    );

    assign full = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign push = w_en && w_valid && !full;

    always_ff @(posedge wclk) begin
        if (push) mem[wbin[AW-1:0]] <= w_data;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin       <= '0;
            wgray      <= '0;
            w_drop_tgl <= 1'b0;
        end else begin
            if (push) begin
                wbin  <= wbin + 1'b1;
                wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
            end
            if (w_en && w_valid && full) w_drop_tgl <= ~w_drop_tgl;
        end
    end

    p_full_drop_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_en && w_valid && full) |=> $stable(wbin));

    // ---------------- read side ----------------
    cdr_sync #(.W(AW+1)) u_wsync (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
    );

    assign wbin_r  = gray2bin(wgray_r);
    assign r_level = wbin_r - rbin;
    assign empty   = (r_level == '0);
    assign r_data  = empty ? '0 : mem[rbin[AW-1:0]];

    always_comb begin
        rbin_nx = rbin;
        if (r_flush)             rbin_nx = wbin_r;
        else if (r_pop && !empty) rbin_nx = rbin + 1'b1;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    p_empty_read_hold_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
        (r_pop && empty && !r_flush) |=> (rbin == $past(rbin)));

    p_level_bound_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
        r_level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/cdr_req_fsm.sv
module cdr_req_fsm
    import cdr_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_en,
    input  logic        burst_sel,
    input  logic [AW:0] level,
    input  logic        rd_strobe,
    output logic        dma_req
);
    localparam logic [AW:0] NEED_BURST  = (AW+1)'(BURST_BEATS);
    localparam logic [AW:0] NEED_SINGLE = (AW+1)'(1);

    req_state_t  state, state_nx;
    logic [1:0]  beats, beats_nx;
    logic        burst_lat, burst_lat_nx;
    logic [AW:0] need_now;
    logic [1:0]  last_beat;

    assign need_now  = burst_sel ? NEED_BURST : NEED_SINGLE;
    assign last_beat = burst_lat ? 2'(BURST_BEATS - 1) : 2'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            beats     <= '0;
            burst_lat <= 1'b0;
        end else begin
            state     <= state_nx;
            beats     <= beats_nx;
            burst_lat <= burst_lat_nx;
        end
    end

    always_comb begin
        state_nx     = state;
        beats_nx     = beats;
        burst_lat_nx = burst_lat;
        unique case (state)
            ST_IDLE: if (cap_en) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (!cap_en) state_nx = ST_IDLE;
                else if (level >= need_now) begin
                    state_nx     = ST_REQ;
                    burst_lat_nx = burst_sel;
                    beats_nx     = '0;
                end
            end
            ST_REQ: begin
                if (!cap_en) state_nx = ST_IDLE;
                else if (rd_strobe) begin
                    if (beats == last_beat) begin
                        state_nx = ST_GAP;
                        beats_nx = '0;
                    end else begin
                        beats_nx = beats + 2'd1;
                    end
                end
            end
            ST_GAP: state_nx = cap_en ? ST_WAIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        dma_req = (state == ST_REQ);
    end

    p_drop_on_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> !dma_req);

    p_burst_threshold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && burst_sel && level < NEED_BURST) |=> !dma_req);

    p_req_has_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> ($past(level) >= NEED_SINGLE));

    p_gap_after_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && rd_strobe && beats == last_beat) |=> !dma_req);
endmodule

// File: rtl/cap_dma_requester.sv
module cap_dma_requester
    import cdr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              pclk,
    input  logic              prst_n,
    input  logic              px_valid,
    input  logic [WORD_W-1:0] px_word,
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              cap_en,
    input  logic              burst_sel,
    output logic              dma_req,
    input  logic              rd_strobe,
    output logic [WORD_W-1:0] rd_data,
    output logic              ovf_flag
);
    localparam int AW = $clog2(DEPTH);

    logic        en_p;
    logic        drop_tgl, drop_s, drop_d;
    logic [AW:0] level;

    cdr_sync #(.W(1)) u_en_sync (
        .clk(pclk), .rst_n(prst_n), .d(cap_en), .q(en_p)
    );

    cdr_afifo #(.DW(WORD_W), .AW(AW)) u_fifo (
        .wclk(pclk), .wrst_n(prst_n), .w_en(en_p), .w_valid(px_valid),
        .w_data(px_word), .w_drop_tgl(drop_tgl),
        .rclk(bclk), .rrst_n(brst_n), .r_flush(!cap_en), .r_pop(rd_strobe),
        .r_data(rd_data), .r_level(level)
    );

    cdr_req_fsm #(.AW(AW)) u_fsm (
        .clk(bclk), .rst_n(brst_n), .cap_en(cap_en), .burst_sel(burst_sel),
        .level(level), .rd_strobe(rd_strobe), .dma_req(dma_req)
    );

    cdr_sync #(.W(1)) u_drop_sync (
        .clk(bclk), .rst_n(brst_n), .d(drop_tgl), .q(drop_s)
    );

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            drop_d   <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            drop_d <= drop_s;
            if (!cap_en)              ovf_flag <= 1'b0;
            else if (drop_s ^ drop_d) ovf_flag <= 1'b1;
        end
    end

    p_ovf_sticky_r6: assert property (@(posedge bclk) disable iff (!brst_n)
        (ovf_flag && cap_en) |=> ovf_flag);

    p_ovf_clear_r7: assert property (@(posedge bclk) disable iff (!brst_n)
        !cap_en |=> !ovf_flag);
endmodule

// File: tb/tb_cap_dma_requester.sv
module tb_cap_dma_requester;
    logic        pclk = 0, bclk = 0;
    logic        prst_n = 0, brst_n = 0;
    logic        px_valid = 0;
    logic [31:0] px_word = '0;
    logic        cap_en = 0, burst_sel = 0, rd_strobe = 0;
    logic        dma_req, ovf_flag;
    logic [31:0] rd_data;

    int errors = 0, checks = 0;
    logic [31:0] q[$];
    logic        done = 0;

    always #2.5 bclk = ~bclk;   // 200 MHz
    always #7   pclk = ~pclk;   // pixel clock well below bus/2.5

    cap_dma_requester dut (
        .pclk(pclk), .prst_n(prst_n), .px_valid(px_valid), .px_word(px_word),
        .bclk(bclk), .brst_n(brst_n), .cap_en(cap_en), .burst_sel(burst_sel),
        .dma_req(dma_req), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int need_of(input bit b);
        return b ? 4 : 1;
    endfunction

    task automatic push_words(input int n, input bit model);
        for (int i = 0; i < n; i++) begin
            @(negedge pclk);
            px_valid = 1;
            px_word  = $urandom;
            if (model) q.push_back(px_word);
        end
        @(negedge pclk);
        px_valid = 0;
    endtask

    task automatic wait_req(output bit got);
        got = 0;
        for (int i = 0; i < 60 && !got; i++) begin
            @(negedge bclk);
            if (dma_req) got = 1;
        end
    endtask

    task automatic serve(input string tag);
        bit got;
        int n = need_of(burst_sel);
        wait_req(got);
        chk(got, tag, {31'd0, dma_req}, 32'd1);
        for (int k = 0; k < n; k++) begin
            rd_strobe = 1;
            #1;
            chk(rd_data == q[0], "R4 read order", rd_data, q[0]);
            chk(dma_req, "R3 held until last read", {31'd0, dma_req}, 32'd1);
            void'(q.pop_front());
            @(negedge bclk);
        end
        rd_strobe = 0;
        chk(!dma_req, "R3 low after last read", {31'd0, dma_req}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge bclk);
        prst_n = 1; brst_n = 1;
        @(negedge bclk);
        chk(!dma_req, "R8 reset req", {31'd0, dma_req}, 0);
        chk(!ovf_flag, "R8 reset ovf", {31'd0, ovf_flag}, 0);
        chk(rd_data == 0, "R8 reset data", rd_data, 0);

        cap_en = 1;
        repeat (10) @(negedge bclk);

        // R5: empty read returns zero and disturbs nothing
        rd_strobe = 1; #1;
        chk(rd_data == 0, "R5 empty read zero", rd_data, 0);
        @(negedge bclk); rd_strobe = 0;
        push_words(1, 1);
        repeat (6) @(negedge bclk);
        serve("R5 R1 req after empty read");

        // R2: three words in burst mode raise nothing
        burst_sel = 1;
        push_words(3, 1);
        repeat (15) @(negedge bclk);
        chk(!dma_req, "R2 below threshold", {31'd0, dma_req}, 0);
        push_words(1, 1);
        repeat (6) @(negedge bclk);
        serve("R2 burst req at four");

        // random phase
        for (int it = 0; it < 40; it++) begin
            int n;
            burst_sel = $urandom % 2;
            n = 1 + ($urandom % (8 - q.size()));
            push_words(n, 1);
            repeat (6) @(negedge bclk);
            while (q.size() >= need_of(burst_sel))
                serve(burst_sel ? "R2 random burst req" : "R1 random single req");
            repeat (12) @(negedge bclk);
            chk(!dma_req, "R2 R1 idle with too few words", {31'd0, dma_req}, 0);
        end

        // drain leftover in single mode
        burst_sel = 0;
        while (q.size() > 0) serve("R1 drain");

        // R6: overflow, no reads
        burst_sel = 1;
        push_words(12, 0);
        repeat (10) @(negedge bclk);
        chk(ovf_flag, "R6 overflow set", {31'd0, ovf_flag}, 1);
        repeat (20) @(negedge bclk);
        chk(ovf_flag, "R6 overflow sticky", {31'd0, ovf_flag}, 1);

        // R7: disable flushes
        cap_en = 0;
        @(negedge bclk);
        chk(!dma_req, "R7 req dropped", {31'd0, dma_req}, 0);
        chk(!ovf_flag, "R7 ovf cleared", {31'd0, ovf_flag}, 0);
        repeat (20) @(negedge bclk);
        burst_sel = 0;
        cap_en = 1;
        repeat (20) @(negedge bclk);
        chk(!dma_req, "R7 no stale req", {31'd0, dma_req}, 0);
        rd_strobe = 1; #1;
        chk(rd_data == 0, "R7 flushed data", rd_data, 0);
        @(negedge bclk); rd_strobe = 0;
        push_words(2, 1);
        repeat (6) @(negedge bclk);
        serve("R7 R1 after re-enable");
        serve("R7 R1 second word");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bclk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R3 actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule